// File: doc/BRIEF.md
# Banked Memory Window Decoder for a 16-bit Bus

This block places a one-megabyte memory window on a 16-bit system bus that has a 24-bit byte address, active-low read and write strobes, and an active-low high-byte enable. The window does not start on a multiple of its own size: it begins at byte address C0000H and ends at 1BFFFFH. The seven upper address bits therefore pass through a range compare and a subtraction to pick one of eight banks. They cannot be used as a plain bank field.

Each bank is a 16-bit store with a separate select for its even (low) byte and its odd (high) byte. The block raises the module select, the per-bank byte selects, the bank write enable, and the enable and direction of the data buffer between the bus and the banks. A behavioural model of the bank storage sits behind the selects, so that writes and reads can be followed from end to end. For a small elaboration, the model keeps only the low `STORE_W` bits of each bank's word address.

Top module: `isa_mem_module`

## Requirements
- R1: While `rst_n` is low, and until the first rising clock edge that samples `rst_n` high, `module_sel_n`, every `cs_lo_n`/`cs_hi_n` bit, `bank_we_n` and `dbuf_en_n` stay high (deasserted), whatever the bus does.
- R2: After reset, `module_sel_n` is low exactly when the block number `bus_addr[23:17]` lies in 6..13 and exactly one of `bus_rd_n` and `bus_wr_n` is low.
- R3: When selected, only bank `bus_addr[23:17] - 6` has its byte selects asserted. Selects of all other banks stay high.
- R4: When both strobes are low, or both are high, the module is not selected: no chip select, no bank write, and the buffer is disabled.
- R5: When selected, the low-byte select is low if `bus_addr[0]` is 0, and the high-byte select is low if `bus_bhe_n` is 0. With A0=1 and BHE high, neither select is asserted.
- R6: `dbuf_en_n` is low exactly while the module is selected. `dbuf_to_bus` is 1 while `bus_rd_n` is low and 0 otherwise.
- R7: `bank_we_n` is low only during a selected write. At that rising clock edge each enabled lane stores its byte (low lane from `bus_wdata[7:0]`, high lane from `bus_wdata[15:8]`), and disabled lanes and other words keep their contents.
- R8: During a selected read, `bus_rdata` carries the stored bytes of the enabled lanes in their own lane positions, with zero in any disabled lane. At all other times `bus_rdata` is zero (the bus is not driven).
- R9: Each bank holds 2^`STORE_W` words indexed by `bus_addr[STORE_W:1]`. Word addresses that differ only in higher bits of `bus_addr[16:1]` reach the same stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes land on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (24) | Byte address from the bus |
| bus_rd_n | input | 1 | Memory read strobe, active low |
| bus_wr_n | input | 1 | Memory write strobe, active low |
| bus_bhe_n | input | 1 | High-byte enable, active low |
| bus_wdata | input | DATA_W (16) | Write data from the bus |
| bus_rdata | output | DATA_W (16) | Read data toward the bus, zero when not driven |
| module_sel_n | output | 1 | Module select, active low |
| cs_lo_n | output | NUM_BANKS (8) | Per-bank low-byte chip select, active low |
| cs_hi_n | output | NUM_BANKS (8) | Per-bank high-byte chip select, active low |
| bank_we_n | output | 1 | Bank write enable, active low |
| dbuf_en_n | output | 1 | Data buffer enable, active low |
| dbuf_to_bus | output | 1 | Buffer direction, 1 = banks drive the bus |

## Verification
The bench uses the default parameters: eight banks, base block 6, 24 address bits, and `STORE_W` = 6. The small store lets a fill pass write every word of every bank before random traffic begins, so each read has a known expected value. The small store also makes aliasing (R9) reachable with a single directed pair of writes. With eight banks and a base of 6, the out-of-window blocks 5 and 14 on either side of the window, and the first and last bank, can all be hit directly. Random addresses also fall outside the window often enough to exercise deselection.

// File: rtl/isa_mem_pkg.sv
`timescale 1ns/1ps
// Shared types for the banked memory window.
// Assumes the bus carries two byte lanes (even = low, odd = high).
package isa_mem_pkg;

    // Kind of bus cycle, decoded from the pair of active-low strobes.
    typedef enum logic [1:0] {
        XFER_IDLE  = 2'b00,
        XFER_READ  = 2'b01,
        XFER_WRITE = 2'b10,
        XFER_CLASH = 2'b11
    } xfer_t;

    localparam int LANES = 2;

    // Classify the strobe pair; both low counts as a clash.
    function automatic xfer_t classify(input logic rd_n, input logic wr_n);
        case ({rd_n, wr_n})
            2'b01:   return XFER_READ;
            2'b10:   return XFER_WRITE;
            2'b00:   return XFER_CLASH;
            default: return XFER_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/isa_win_decode.sv
`timescale 1ns/1ps
// Window decoder: turns the block number (upper address bits) into an
// in-window hit, a bank index and a one-hot bank vector.
// Assumes the window spans NUM_BANKS consecutive blocks from BASE_BLOCK.
module isa_win_decode #(
    parameter int HI_W       = 7,
    parameter int NUM_BANKS  = 8,
    parameter int BASE_BLOCK = 6,
    parameter int SEL_W      = 3
) (
    input  logic [HI_W-1:0]      blk_num,
    output logic                 win_hit,
    output logic [SEL_W-1:0]     bank_idx,
    output logic [NUM_BANKS-1:0] bank_onehot
);
    localparam logic [HI_W-1:0] FIRST_BLK = HI_W'(BASE_BLOCK);
    localparam logic [HI_W-1:0] LAST_BLK  = HI_W'(BASE_BLOCK + NUM_BANKS - 1);

    logic [HI_W-1:0] blk_offset;
    logic            unused_offset_hi;

    // Range compare: the window is not aligned to its size.
    assign win_hit    = (blk_num >= FIRST_BLK) && (blk_num <= LAST_BLK);
    // Bank index is the distance from the first block of the window.
    assign blk_offset = blk_num - FIRST_BLK;
    assign bank_idx   = blk_offset[SEL_W-1:0];
    assign unused_offset_hi = ^blk_offset[HI_W-1:SEL_W];

    // One select line per bank, gated by the window hit.
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank_sel
        assign bank_onehot[g] = win_hit && (bank_idx == SEL_W'(g));
    end

endmodule

// File: rtl/isa_lane_ctrl.sv
`timescale 1ns/1ps
// Cycle and lane control: decides whether the module takes part in the
// current bus cycle, which byte lanes it uses, and how the buffer and
// write enable behave. Assumes single-cycle strobes and no wait states.
module isa_lane_ctrl
    import isa_mem_pkg::*;
(
    input  logic             live,
    input  logic             win_hit,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic             a0,
    input  logic             bhe_n,
    output logic             active,
    output logic             rd_active,
    output logic             wr_active,
    output logic [LANES-1:0] lane_en,
    output logic             buf_to_bus
);
    xfer_t xfer;

    // Classify the strobes and gate the cycle with window hit and reset state.
    always_comb begin
        xfer      = classify(rd_n, wr_n);
        active    = live && win_hit && ((xfer == XFER_READ) || (xfer == XFER_WRITE));
        rd_active = active && (xfer == XFER_READ);
        wr_active = active && (xfer == XFER_WRITE);
    end

    // Byte lanes: even lane follows A0, odd lane follows the high enable.
    always_comb begin
        lane_en[0] = active && !a0;
        lane_en[1] = active && !bhe_n;
    end

    // Buffer direction follows the read strobe.
    assign buf_to_bus = !rd_n;

endmodule

// File: rtl/isa_bank_store.sv
`timescale 1ns/1ps
// Behavioural bank storage: one byte array per lane, shared by all banks,
// addressed by {bank, word}. Writes on the rising edge, reads are
// combinational. Assumes only the low STORE_W word bits are kept.
module isa_bank_store
    import isa_mem_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int SEL_W     = 3,
    parameter int STORE_W   = 6,
    parameter int DATA_W    = 16
) (
    input  logic              clk,
    input  logic [SEL_W-1:0]  bank_idx,
    input  logic [STORE_W-1:0] word_idx,
    input  logic [LANES-1:0]  lane_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH_ALL = NUM_BANKS << STORE_W;
    localparam int FLAT_W    = SEL_W + STORE_W;

    logic [FLAT_W-1:0] flat_addr;

    assign flat_addr = {bank_idx, word_idx};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] mem [DEPTH_ALL];

        // Store this lane's byte when the lane takes part in a write.
        always_ff @(posedge clk) begin
            if (wr_en && lane_en[g]) begin
                mem[flat_addr] <= wdata[g*8 +: 8];
            end
        end

        // Present this lane's byte only when the lane is enabled.
        assign rdata[g*8 +: 8] = lane_en[g] ? mem[flat_addr] : 8'h00;
    end

endmodule

// File: rtl/isa_mem_module.sv
`timescale 1ns/1ps
// Top of the memory window: decodes the window, drives per-bank byte
// chip selects, write enable and data buffer control, and holds the
// behavioural bank storage. Reset is synchronous and active low; all
// selects stay off until the first edge that sees reset released.
module isa_mem_module
    import isa_mem_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int DATA_W      = 16,
    parameter int NUM_BANKS   = 8,
    parameter int BANK_WORD_W = 16,
    parameter int BASE_BLOCK  = 6,
    parameter int STORE_W     = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_rd_n,
    input  logic                 bus_wr_n,
    input  logic                 bus_bhe_n,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 module_sel_n,
    output logic [NUM_BANKS-1:0] cs_lo_n,
    output logic [NUM_BANKS-1:0] cs_hi_n,
    output logic                 bank_we_n,
    output logic                 dbuf_en_n,
    output logic                 dbuf_to_bus
);
    localparam int HI_W  = ADDR_W - 1 - BANK_WORD_W;
    localparam int SEL_W = $clog2(NUM_BANKS);

    logic                 armed;
    logic                 live;
    logic                 win_hit;
    logic [SEL_W-1:0]     bank_idx;
    logic [NUM_BANKS-1:0] bank_onehot;
    logic                 active;
    logic                 rd_active;
    logic                 wr_active;
    logic [LANES-1:0]     lane_en;
    logic [DATA_W-1:0]    store_rdata;
    logic                 unused_word_hi;

    // Arm the decoder on the first clock edge that samples reset released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
        end
    end

    assign live = armed && rst_n;
    assign unused_word_hi = ^bus_addr[BANK_WORD_W:STORE_W+1];

    isa_win_decode #(
        .HI_W       (HI_W),
        .NUM_BANKS  (NUM_BANKS),
        .BASE_BLOCK (BASE_BLOCK),
        .SEL_W      (SEL_W)
    ) u_decode (
        .blk_num     (bus_addr[ADDR_W-1:BANK_WORD_W+1]),
        .win_hit     (win_hit),
        .bank_idx    (bank_idx),
        .bank_onehot (bank_onehot)
    );

    isa_lane_ctrl u_lanes (
        .live       (live),
        .win_hit    (win_hit),
        .rd_n       (bus_rd_n),
        .wr_n       (bus_wr_n),
        .a0         (bus_addr[0]),
        .bhe_n      (bus_bhe_n),
        .active     (active),
        .rd_active  (rd_active),
        .wr_active  (wr_active),
        .lane_en    (lane_en),
        .buf_to_bus (dbuf_to_bus)
    );

    isa_bank_store #(
        .NUM_BANKS (NUM_BANKS),
        .SEL_W     (SEL_W),
        .STORE_W   (STORE_W),
        .DATA_W    (DATA_W)
    ) u_store (
        .clk      (clk),
        .bank_idx (bank_idx),
        .word_idx (bus_addr[STORE_W:1]),
        .lane_en  (lane_en),
        .wr_en    (wr_active),
        .wdata    (bus_wdata),
        .rdata    (store_rdata)
    );

    // Per-bank byte chip selects from the one-hot bank and the lane enables.
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_cs
        assign cs_lo_n[g] = !(bank_onehot[g] && lane_en[0]);
        assign cs_hi_n[g] = !(bank_onehot[g] && lane_en[1]);
    end

    // Module select, write enable, buffer enable and read data toward the bus.
    always_comb begin
        module_sel_n = !active;
        bank_we_n    = !wr_active;
        dbuf_en_n    = !active;
        bus_rdata    = rd_active ? store_rdata : '0;
    end

endmodule

// File: rtl/isa_mem_module_chk.sv
`timescale 1ns/1ps
// Property checker for the memory window, bound to the top module.
// Assumes the same parameters as the top; sees only its ports.
module isa_mem_module_chk #(
    parameter int ADDR_W      = 24,
    parameter int DATA_W      = 16,
    parameter int NUM_BANKS   = 8,
    parameter int BANK_WORD_W = 16,
    parameter int BASE_BLOCK  = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_rd_n,
    input logic                 bus_wr_n,
    input logic                 bus_bhe_n,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic                 module_sel_n,
    input logic [NUM_BANKS-1:0] cs_lo_n,
    input logic [NUM_BANKS-1:0] cs_hi_n,
    input logic                 bank_we_n,
    input logic                 dbuf_en_n,
    input logic                 dbuf_to_bus
);
    logic [31:0] blk;
    assign blk = 32'(bus_addr >> (BANK_WORD_W + 1));

    p_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !module_sel_n |-> (blk >= 32'(BASE_BLOCK)) && (blk < 32'(BASE_BLOCK + NUM_BANKS)));

    p_cs_needs_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(&(cs_lo_n & cs_hi_n)) |-> !module_sel_n);

    p_one_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~(cs_lo_n & cs_hi_n)));

    p_strobe_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_n == bus_wr_n) |-> module_sel_n && bank_we_n && dbuf_en_n);

    p_lane_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr[0] |-> (&cs_lo_n));

    p_lane_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_bhe_n |-> (&cs_hi_n));

    p_buf_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dbuf_en_n == module_sel_n);

    p_buf_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !dbuf_en_n |-> (dbuf_to_bus == !bus_rd_n));

    p_we_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_we_n |-> !bus_wr_n && !module_sel_n);

    p_idle_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dbuf_en_n || bus_rd_n) |-> (bus_rdata == '0));

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> module_sel_n && bank_we_n && dbuf_en_n);

endmodule

bind isa_mem_module isa_mem_module_chk #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .NUM_BANKS   (NUM_BANKS),
    .BANK_WORD_W (BANK_WORD_W),
    .BASE_BLOCK  (BASE_BLOCK)
) u_chk (.*);

// File: tb/isa_mem_module_tb.sv
`timescale 1ns/1ps
// Bench for the memory window: directed corners plus seeded random
// traffic, compared against a byte-lane reference model.
module isa_mem_module_tb;
    localparam int NB    = 8;
    localparam int SW    = 6;
    localparam int BASE  = 6;
    localparam int DEPTH = 1 << SW;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [23:0] bus_addr;
    logic        bus_rd_n, bus_wr_n, bus_bhe_n;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        module_sel_n;
    logic [7:0]  cs_lo_n, cs_hi_n;
    logic        bank_we_n, dbuf_en_n, dbuf_to_bus;

    always #2 clk = ~clk;

    isa_mem_module #(.STORE_W(SW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .bus_bhe_n(bus_bhe_n), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .module_sel_n(module_sel_n), .cs_lo_n(cs_lo_n),
        .cs_hi_n(cs_hi_n), .bank_we_n(bank_we_n), .dbuf_en_n(dbuf_en_n),
        .dbuf_to_bus(dbuf_to_bus)
    );

    int  n_chk = 0;
    int  n_err = 0;
    bit  tb_armed = 1'b0;
    logic [7:0] m_lo [NB*DEPTH];
    logic [7:0] m_hi [NB*DEPTH];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int flat_of(input logic [23:0] a);
        return (int'(a[23:17]) - BASE) * DEPTH + int'(a[SW:1]);
    endfunction

    // One bus cycle: drive at the falling edge, check before the rising edge.
    task automatic bus_op(input logic [23:0] a, input logic rd_n, input logic wr_n,
                          input logic bhe_n, input logic [15:0] wd, input string rtag);
        bit in_win, sel, lo_en, hi_en;
        int bank, idx;
        logic [7:0]  exp_lo_cs, exp_hi_cs;
        logic [15:0] exp_rd;
        string stag;
        @(negedge clk);
        bus_addr = a; bus_rd_n = rd_n; bus_wr_n = wr_n; bus_bhe_n = bhe_n; bus_wdata = wd;
        #1;
        in_win = (a[23:17] >= 7'(BASE)) && (a[23:17] < 7'(BASE + NB));
        sel    = tb_armed && in_win && (rd_n != wr_n);
        bank   = int'(a[23:17]) - BASE;
        lo_en  = sel && !a[0];
        hi_en  = sel && !bhe_n;
        exp_lo_cs = 8'hFF; exp_hi_cs = 8'hFF;
        if (lo_en) exp_lo_cs[bank] = 1'b0;
        if (hi_en) exp_hi_cs[bank] = 1'b0;
        idx    = sel ? flat_of(a) : 0;
        exp_rd = 16'h0;
        if (sel && !rd_n) exp_rd = {hi_en ? m_hi[idx] : 8'h00, lo_en ? m_lo[idx] : 8'h00};
        stag = !tb_armed ? "R1" : ((rd_n == wr_n) ? "R4" : "R2");
        check(module_sel_n == !sel, stag, "module_sel_n", 32'(module_sel_n), 32'(!sel));
        check(cs_lo_n == exp_lo_cs, sel ? "R3" : stag, "cs_lo_n", 32'(cs_lo_n), 32'(exp_lo_cs));
        check(cs_hi_n == exp_hi_cs, sel ? "R5" : stag, "cs_hi_n", 32'(cs_hi_n), 32'(exp_hi_cs));
        check(bank_we_n == !(sel && !wr_n), sel ? "R7" : stag, "bank_we_n",
              32'(bank_we_n), 32'(!(sel && !wr_n)));
        check(dbuf_en_n == !sel, sel ? "R6" : stag, "dbuf_en_n", 32'(dbuf_en_n), 32'(!sel));
        check(dbuf_to_bus == !rd_n, "R6", "dbuf_to_bus", 32'(dbuf_to_bus), 32'(!rd_n));
        check(bus_rdata == exp_rd, rtag, "bus_rdata", 32'(bus_rdata), 32'(exp_rd));
        if (sel && !wr_n) begin
            if (lo_en) m_lo[idx] = wd[7:0];
            if (hi_en) m_hi[idx] = wd[15:8];
        end
    endtask

    function automatic logic [23:0] mk_addr(input int blk, input int word, input bit a0);
        return {7'(blk), 16'(word), a0};
    endfunction

    initial begin
        #800000;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd20251));
        rst_n = 1'b0; bus_addr = '0; bus_rd_n = 1'b1; bus_wr_n = 1'b1;
        bus_bhe_n = 1'b1; bus_wdata = '0;
        repeat (3) @(posedge clk);
        // R1: a full-window read and a write during reset select nothing.
        bus_op(mk_addr(BASE + 2, 5, 1'b0), 1'b0, 1'b1, 1'b0, 16'h0, "R1");
        bus_op(mk_addr(BASE + 2, 5, 1'b0), 1'b1, 1'b0, 1'b0, 16'hDEAD, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        tb_armed = 1'b1;

        // R7: fill every word of every bank with full-word writes.
        for (int b = 0; b < NB; b++) begin
            for (int w = 0; w < DEPTH; w++) begin
                bus_op(mk_addr(BASE + b, w, 1'b0), 1'b1, 1'b0, 1'b0, 16'($urandom), "R8");
            end
        end

        // R2: blocks just outside the window, and its two ends.
        bus_op(24'h0BFFFE, 1'b0, 1'b1, 1'b0, 16'h0, "R2");
        bus_op(24'h1C0000, 1'b0, 1'b1, 1'b0, 16'h0, "R2");
        bus_op(24'h0C0000, 1'b0, 1'b1, 1'b0, 16'h0, "R3");
        bus_op(24'h1BFFFE, 1'b0, 1'b1, 1'b0, 16'h0, "R3");
        // R4: both strobes low must not write; read back the same word.
        bus_op(mk_addr(BASE + 3, 9, 1'b0), 1'b0, 1'b0, 1'b0, 16'h1234, "R4");
        bus_op(mk_addr(BASE + 3, 9, 1'b0), 1'b0, 1'b1, 1'b0, 16'h0, "R4");
        // R5: odd-byte write, then whole-word read shows the even byte kept.
        bus_op(mk_addr(BASE + 4, 11, 1'b1), 1'b1, 1'b0, 1'b0, 16'hA55A, "R5");
        bus_op(mk_addr(BASE + 4, 11, 1'b0), 1'b0, 1'b1, 1'b0, 16'h0, "R7");
        // R5: even-byte only write and read.
        bus_op(mk_addr(BASE + 4, 12, 1'b0), 1'b1, 1'b0, 1'b1, 16'h77C3, "R5");
        bus_op(mk_addr(BASE + 4, 12, 1'b0), 1'b0, 1'b1, 1'b0, 16'h0, "R7");
        // R5: odd address with high enable off selects no lane; data stays zero.
        bus_op(mk_addr(BASE + 1, 2, 1'b1), 1'b0, 1'b1, 1'b1, 16'h0, "R8");
        // R9: a higher word bit aliases onto the same stored word.
        bus_op(mk_addr(BASE + 5, 3 + DEPTH, 1'b0), 1'b1, 1'b0, 1'b0, 16'hBEEF, "R9");
        bus_op(mk_addr(BASE + 5, 3, 1'b0), 1'b0, 1'b1, 1'b0, 16'h0, "R9");
        // R8: idle bus leaves read data at zero.
        bus_op(mk_addr(BASE, 0, 1'b0), 1'b1, 1'b1, 1'b0, 16'h0, "R8");

        // Seeded random traffic, mostly inside the window.
        for (int i = 0; i < 3000; i++) begin
            logic [23:0] a;
            int kind;
            logic rd_n, wr_n;
            if (($urandom % 4) != 0) a = mk_addr(BASE + int'($urandom % NB), int'($urandom), 1'($urandom));
            else a = 24'($urandom);
            kind = int'($urandom % 8);
            rd_n = !(kind < 4 || kind == 7);
            wr_n = !(kind >= 4);
            if (kind == 7 && ($urandom % 2) == 0) begin rd_n = 1'b1; wr_n = 1'b1; end
            bus_op(a, rd_n, wr_n, 1'($urandom), 16'($urandom), "R8");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule